// File: doc/BRIEF.md
# Serial Character Transmitter with Idle and Break Queuing

This block turns parallel characters into an asynchronous serial stream on a line that rests high. Software writes a character into a one-entry holding register. The `empty` flag tells software when that character has moved into the shifter and the next one can be written. Each bit lasts one period of an external bit-time strobe. The character length can be 8 or 9 data bits, and the frame can end with one or two stop bits.

Two special characters can be placed ahead of the data. An idle character holds the line high for one full frame time, which wakes receivers that sleep between messages. Software requests one by taking the enable low and then high again, usually after `empty` has risen on the last character of a message. A break character holds the line low. Its length depends on the data length, the stop-bit count and a long-break select.

The shifter always finishes the character it is sending before the line changes hands. The idle character therefore follows the last character without a gap, even if the enable stays low for several bit times in the middle of that character.

Top module: `sertx_core`

## Requirements
- R1: A data frame is one low start bit, then the data bits least significant first (wr_data bits 0..7, plus bit 8 only when `nine_bit` is 1), then one high stop bit, or two when `two_stop` is 1. The configuration is sampled when a character enters the shifter.
- R2: Every serial bit lasts exactly one bit-time strobe. `txd` changes only on a clock edge at which `bit_tick` is 1.
- R3: `empty` is 0 from the clock edge after a write. It becomes 1 on the strobe edge at which the shifter takes the held character.
- R4: Each low-to-high change of `tx_en` queues one idle character. This includes the first one after reset. The idle character drives the line high for the configured frame length (2 + data bits + extra stop bit) and starts as soon as the shifter is free.
- R5: Taking `tx_en` low while a character is being shifted does not shorten or alter that character.
- R6: While `tx_en` is 0 and the shifter is free, `txd` stays 1 and no held character, idle or break is started.
- R7: A break drives the line low for the number of bit times given by {long_brk, nine_bit, two_stop}: 000→10, 001→11, 010→11, 011→12, 100→13, 101→14, 110→14, 111→15.
- R8: When the shifter becomes free with `tx_en` at 1, a break request (level of `brk_req`) wins over a pending idle character, which wins over a held data character.
- R9: A write made while the holding register is still full replaces the held character. Only the last value written is sent.
- R10: During and right after reset, `txd` is 1 and `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-clock strobe per serial bit time |
| tx_en | input | 1 | Transmitter enable; a rising edge queues an idle character |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| two_stop | input | 1 | 1 selects two stop bits |
| long_brk | input | 1 | 1 selects the longer break lengths |
| brk_req | input | 1 | Break request, sampled when the shifter becomes free |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_BITS+1 | Character to send; the top bit is used only in 9-bit mode |
| empty | output | 1 | Holding register can accept a new character |
| txd | output | 1 | Serial line, high when idle |

## Verification
On every cycle, the embedded assertions check several properties. The line changes only on strobe edges. The line is low throughout a break and high whenever the shifter holds an idle character or nothing. It stays high after a free strobe while the enable is low. A write always leaves the register full, `empty` rises only when the shifter takes a character, and the break length matches its relation to the frame length. Other behaviour can only be shown by the bench's scenarios, where a scoreboard compares every bit time against an expected stream. These are the exact bit order of frames in every configuration, the full break table, the idle length and its ordering after an interrupted enable, the three-way priority, and the replacement of a held character written while disabled.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   // What the shifter is currently putting on the line
   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_DATA = 2'd1,
      K_IDLE = 2'd2,
      K_BRK  = 2'd3
   } sertx_kind_e;
endpackage

// File: rtl/sertx_len.sv
module sertx_len #(
   parameter int DATA_BITS = 8,
   parameter int LEN_W     = 5,
   parameter bit USE_LUT   = 1'b1
) (
   input  logic             nine_bit,
   input  logic             two_stop,
   input  logic             long_brk,
   output logic [LEN_W-1:0] frame_len,
   output logic [LEN_W-1:0] brk_len
);
   localparam int BASE_LEN = 2 + DATA_BITS;

   assign frame_len = LEN_W'(BASE_LEN) + LEN_W'(nine_bit) + LEN_W'(two_stop);

   generate
      if (USE_LUT) begin : g_lut
         logic [2:0] brk_off;
         always_comb begin
            case ({long_brk, nine_bit, two_stop})
               3'b000:  brk_off = 3'd0;
               3'b001:  brk_off = 3'd1;
               3'b010:  brk_off = 3'd1;
               3'b011:  brk_off = 3'd2;
               3'b100:  brk_off = 3'd3;
               3'b101:  brk_off = 3'd4;
               3'b110:  brk_off = 3'd4;
               default: brk_off = 3'd5;
            endcase
         end
         assign brk_len = LEN_W'(BASE_LEN) + LEN_W'(brk_off);
      end else begin : g_arith
         assign brk_len = frame_len + (long_brk ? LEN_W'(3) : LEN_W'(0));
      end
   endgenerate
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [WORD_W-1:0] held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= '0;
      end else begin
         if (wr_en) begin
            full <= 1'b1;
            held <= wr_data;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

   assert_write_fills_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> full);
   assert_empty_on_take_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full) |-> $past(take));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int SH_W  = 16,
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  sertx_kind_e      ld_kind,
   input  logic [SH_W-1:0]  ld_vec,
   input  logic [LEN_W-1:0] ld_len,
   output logic             txd,
   output logic             free,
   output sertx_kind_e      kind
);
   logic [SH_W-1:0]  sh;
   logic [LEN_W-1:0] cnt;

   // cnt counts the bits still to show, including the one on the line
   assign free = (cnt <= LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         cnt  <= '0;
         txd  <= 1'b1;
         kind <= K_NONE;
      end else if (tick) begin
         if (load) begin
            txd  <= ld_vec[0];
            sh   <= {1'b1, ld_vec[SH_W-1:1]};
            cnt  <= ld_len;
            kind <= ld_kind;
         end else if (cnt > LEN_W'(1)) begin
            txd <= sh[0];
            sh  <= {1'b1, sh[SH_W-1:1]};
            cnt <= cnt - LEN_W'(1);
         end else begin
            txd  <= 1'b1;
            cnt  <= '0;
            kind <= K_NONE;
         end
      end
   end

   assert_bit_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(txd));
   assert_break_low_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_BRK) |-> !txd);
   assert_rest_high_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_NONE || kind == K_IDLE) |-> txd);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter bit USE_LUT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_tick,
   input  logic                 tx_en,
   input  logic                 nine_bit,
   input  logic                 two_stop,
   input  logic                 long_brk,
   input  logic                 brk_req,
   input  logic                 wr_en,
   input  logic [DATA_BITS:0]   wr_data,
   output logic                 empty,
   output logic                 txd
);
   localparam int WORD_W  = DATA_BITS + 1;
   localparam int MAX_BRK = DATA_BITS + 7;
   localparam int SH_W    = MAX_BRK + 1;
   localparam int LEN_W   = $clog2(MAX_BRK + 1);

   generate
      if (DATA_BITS < 4 || DATA_BITS > 16) begin : g_bad_width
         $error("sertx_core: DATA_BITS must lie in 4..16");
      end
   endgenerate

   logic [LEN_W-1:0] frame_len, brk_len;
   logic             full, take, free, ld, en_q, idle_pend;
   logic [WORD_W-1:0] held;
   logic [SH_W-1:0]  frame_vec, ld_vec;
   logic [LEN_W-1:0] ld_len;
   sertx_kind_e      ld_kind, kind;

   sertx_len #(.DATA_BITS(DATA_BITS), .LEN_W(LEN_W), .USE_LUT(USE_LUT)) u_len (
      .nine_bit (nine_bit),
      .two_stop (two_stop),
      .long_brk (long_brk),
      .frame_len(frame_len),
      .brk_len  (brk_len)
   );

   sertx_hold #(.WORD_W(WORD_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .take   (take),
      .full   (full),
      .held   (held)
   );

   // Start bit, data LSB first, ones for stop bits and unused tail
   always_comb begin
      frame_vec    = '1;
      frame_vec[0] = 1'b0;
      for (int i = 0; i < DATA_BITS; i++) frame_vec[i+1] = held[i];
      if (nine_bit) frame_vec[DATA_BITS+1] = held[DATA_BITS];
   end

   // Source selection at a free bit boundary: break, then idle, then data
   always_comb begin
      ld      = 1'b0;
      ld_kind = K_NONE;
      ld_vec  = '1;
      ld_len  = frame_len;
      if (bit_tick && free && tx_en) begin
         if (brk_req) begin
            ld      = 1'b1;
            ld_kind = K_BRK;
            ld_vec  = '0;
            ld_len  = brk_len;
         end else if (idle_pend) begin
            ld      = 1'b1;
            ld_kind = K_IDLE;
         end else if (full) begin
            ld      = 1'b1;
            ld_kind = K_DATA;
            ld_vec  = frame_vec;
         end
      end
   end

   assign take  = ld && (ld_kind == K_DATA);
   assign empty = !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         idle_pend <= 1'b0;
      end else begin
         en_q <= tx_en;
         if (tx_en && !en_q)
            idle_pend <= 1'b1;
         else if (ld && ld_kind == K_IDLE)
            idle_pend <= 1'b0;
      end
   end

   sertx_shift #(.SH_W(SH_W), .LEN_W(LEN_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (bit_tick),
      .load   (ld),
      .ld_kind(ld_kind),
      .ld_vec (ld_vec),
      .ld_len (ld_len),
      .txd    (txd),
      .free   (free),
      .kind   (kind)
   );

   assert_brk_vs_frame_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      brk_len == frame_len + (long_brk ? LEN_W'(3) : LEN_W'(0)));
   assert_line_high_off_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(bit_tick && free && !tx_en) |-> (txd && kind == K_NONE));
endmodule

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       tx_en = 1'b0, nine_bit = 1'b0, two_stop = 1'b0;
   logic       long_brk = 1'b0, brk_req = 1'b0, wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       empty, txd;

   typedef struct {
      logic  v;
      string tag;
   } exp_t;
   exp_t q[$];

   int   n_chk = 0, n_err = 0, tick_cnt = 0, cyc = 0;
   logic [1:0] div = '0;

   sertx_core dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
      .nine_bit(nine_bit), .two_stop(two_stop), .long_brk(long_brk),
      .brk_req(brk_req), .wr_en(wr_en), .wr_data(wr_data),
      .empty(empty), .txd(txd)
   );

   always #4 clk = ~clk;

   // Strobe generator and scoreboard monitor, both on the falling edge
   always @(negedge clk) begin
      if (bit_tick) begin
         exp_t e;
         tick_cnt++;
         if (q.size() != 0) e = q.pop_front();
         else begin e.v = 1'b1; e.tag = "R6"; end
         n_chk++;
         if (txd !== e.v) begin
            n_err++;
            $display("FAIL %s txd at strobe %0d actual=%0b expected=%0b",
                     e.tag, tick_cnt, txd, e.v);
         end
      end
      div      <= div + 2'd1;
      bit_tick <= (div == 2'd3) && rst_n;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog run did not finish actual=%0d expected<=150000", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic check(input string tag, input logic act, input logic expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
      end
   endtask

   task automatic drive_step();
      @(posedge clk); #2;
   endtask

   task automatic wait_tick();
      int c = tick_cnt;
      do begin @(negedge clk); #1; end while (tick_cnt == c);
   endtask

   task automatic push_bits(input int n, input logic v, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.v = v; e.tag = tag;
         q.push_back(e);
      end
   endtask

   function automatic int frame_bits(input logic nb, input logic ts);
      return 10 + int'(nb) + int'(ts);
   endfunction

   function automatic int brk_bits(input logic lb, input logic nb, input logic ts);
      case ({lb, nb, ts})
         3'b000: return 10;
         3'b001: return 11;
         3'b010: return 11;
         3'b011: return 12;
         3'b100: return 13;
         3'b101: return 14;
         3'b110: return 14;
         default: return 15;
      endcase
   endfunction

   // Driver: expected frame into the scoreboard, then the register write
   task automatic send_char(input logic [8:0] d, input string tag);
      push_bits(1, 1'b0, tag);
      for (int i = 0; i < 8 + int'(nine_bit); i++) push_bits(1, d[i], tag);
      push_bits(1 + int'(two_stop), 1'b1, tag);
      drive_step();
      wr_en = 1'b1; wr_data = d;
      drive_step();
      wr_en = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) wait_tick();
      wait_tick();
      wait_tick();
   endtask

   initial begin
      // R10: reset state
      #21;
      check("R10 txd in reset", txd, 1'b1);
      check("R10 empty in reset", empty, 1'b1);
      drive_step();
      rst_n = 1'b1;
      drive_step();
      check("R10 txd after reset", txd, 1'b1);
      check("R10 empty after reset", empty, 1'b1);

      // R4: first enable queues an idle frame; R1/R3 basic character
      push_bits(10, 1'b1, "R4");
      tx_en = 1'b1;
      drain();
      send_char(9'h0A5, "R1");
      check("R3 empty low after write", empty, 1'b0);
      wait_tick();
      check("R3 empty set on load strobe", empty, 1'b1);
      drain();

      // R1: all data/stop configurations, back to back characters
      for (int cfg = 0; cfg < 4; cfg++) begin
         drive_step();
         nine_bit = cfg[1]; two_stop = cfg[0];
         send_char(9'h13C ^ 9'(cfg * 37), "R1");
         while (empty !== 1'b1) wait_tick();
         send_char(9'h0C3 + 9'(cfg * 91), "R1 back-to-back");
         drain();
      end

      // R7: break length table
      for (int cfg = 0; cfg < 8; cfg++) begin
         drive_step();
         long_brk = cfg[2]; nine_bit = cfg[1]; two_stop = cfg[0];
         push_bits(brk_bits(cfg[2], cfg[1], cfg[0]), 1'b0, "R7");
         brk_req = 1'b1;
         wait_tick();
         drive_step();
         brk_req = 1'b0;
         drain();
      end
      drive_step();
      long_brk = 1'b0;

      // R4/R5: short enable drop mid-character queues a 12-bit idle
      nine_bit = 1'b1; two_stop = 1'b1;
      send_char(9'h155, "R5");
      wait_tick(); wait_tick(); wait_tick();
      drive_step(); tx_en = 1'b0;
      wait_tick(); wait_tick();
      push_bits(frame_bits(1'b1, 1'b1), 1'b1, "R4");
      drive_step(); tx_en = 1'b1;
      send_char(9'h0F0, "R4 after idle");
      drain();

      // R8: break over idle over data
      drive_step();
      nine_bit = 1'b0; two_stop = 1'b0;
      send_char(9'h03C, "R8");
      wait_tick();
      drive_step(); tx_en = 1'b0;
      drive_step(); tx_en = 1'b1; brk_req = 1'b1;
      push_bits(10, 1'b0, "R8 break first");
      push_bits(10, 1'b1, "R8 idle second");
      send_char(9'h099, "R8 data last");
      while (q.size() != 30) wait_tick();
      wait_tick();
      drive_step(); brk_req = 1'b0;
      drain();

      // R5/R6/R9: disable mid-character, write twice while disabled
      send_char(9'h0E1, "R5");
      wait_tick(); wait_tick(); wait_tick();
      drive_step(); tx_en = 1'b0;
      drive_step(); wr_en = 1'b1; wr_data = 9'h011;
      drive_step(); wr_data = 9'h0B6;
      drive_step(); wr_en = 1'b0;
      while (q.size() != 0) wait_tick();
      for (int i = 0; i < 6; i++) wait_tick();
      check("R6 held character not started", empty, 1'b0);
      push_bits(10, 1'b1, "R4 idle on re-enable");
      push_bits(1, 1'b0, "R9");
      for (int i = 0; i < 8; i++) push_bits(1, 1'(9'h0B6 >> i), "R9");
      push_bits(1, 1'b1, "R9");
      tx_en = 1'b1;
      drain();
      check("R3 empty after held character sent", empty, 1'b1);
      check("R6 line high at end", txd, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule